// File: doc/BRIEF.md
# DMA Burst Width Sequencer

This block turns one DMA service burst into a series of bus transfers. The burst belongs to one channel and one direction. A start strobe captures a buffer address, a byte count and a byte-only mode bit. The block then offers transfers one at a time on a valid/ready interface. Each offer carries the low 8 address bits and a flag that says whether the transfer is 16 bits or 8 bits wide.

A 16-bit transfer needs an even address, at least two bytes left, and the byte-only mode clear. Any other case gives an 8-bit transfer. The bits above the low byte are held in an external latch, so the block pulses a load strobe once before the first offer. The burst ends with a `done` pulse when the count is used up. It ends with a `yield` pulse if the next address would leave the latched 256-byte page, so the bus owner can release the bus and fetch it again.

Back-pressure: an offer stays up, with address and width unchanged, until `xfer_ready` is high on a rising edge. One transfer completes on each such edge. The consumer may hold `xfer_ready` low for any number of cycles.

Top module: `dma_burst_seq`

## Requirements
- R1: Out of reset `busy`, `xfer_valid`, `ld_stb`, `done` and `yield` are low. `start` is taken only while `busy` is low. A `start` that arrives while `busy` is high has no effect on the running burst.
- R2: For a nonzero count, `ld_stb` is high for exactly one cycle, which is the cycle after `start`. During that cycle `upper_addr` equals start address bits 31..8. The first offer appears in the cycle that follows, and `ld_stb` does not pulse again in that burst.
- R3: With byte-only mode clear, an offer is 16 bits wide (`xfer_wide`=1) when the current address is even and at least two bytes remain.
- R4: An offer is 8 bits wide (`xfer_wide`=0) when the current address is odd or only one byte remains. So an even start with an odd count ends on one 8-bit transfer, and an odd start begins with one.
- R5: When `force_byte` was high at `start`, every offer of that burst is 8 bits wide.
- R6: `xfer_lo_addr` equals bits 7..0 of the current address. The address and the remaining count both step by 2 after a 16-bit transfer and by 1 after an 8-bit transfer.
- R7: While `xfer_valid` is high and `xfer_ready` is low, the offer stays up with the same `xfer_lo_addr` and `xfer_wide` in the next cycle.
- R8: When the last byte completes, `done` is high for one cycle in the following cycle, and `busy` is low in the cycle after that.
- R9: When a completed transfer leaves bytes remaining but the next address differs from the latched bits 31..8, no further offer is made. `yield` is high for one cycle instead of `done`.
- R10: A count of zero gives `done` in the cycle after `start`, with no `ld_stb` pulse and no offer.
- R11: A count above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst (taken only when idle) |
| start_addr | input | 32 | Buffer byte address |
| byte_count | input | 5 | Bytes to move, clamped to 16 |
| force_byte | input | 1 | Use only 8-bit transfers for this burst |
| busy | output | 1 | A burst is in progress |
| ld_stb | output | 1 | One-cycle strobe that loads the upper address latch |
| upper_addr | output | 24 | Address bits 31..8 for the external latch |
| xfer_valid | output | 1 | A transfer is offered |
| xfer_ready | input | 1 | The consumer takes the offered transfer |
| xfer_lo_addr | output | 8 | Address bits 7..0 of the offered transfer |
| xfer_wide | output | 1 | 1 means a 16-bit transfer, 0 means an 8-bit transfer |
| done | output | 1 | One-cycle pulse: the whole count has moved |
| yield | output | 1 | One-cycle pulse: burst stopped at a page boundary |

## Verification
The two events that can coincide are a transfer handshake and the page-boundary decision. In the same edge that accepts a transfer, the block has to decide between stopping with `done`, stopping with `yield`, and making another offer. Bursts that start just below a 256-byte boundary provoke this with a 16-bit step (0x..FC, 0x..FE) and with a single odd byte (0x..FF). A burst whose last 16-bit transfer lands exactly on the boundary checks that running out of bytes takes priority, so it ends in `done` and not `yield`. Each of these bursts runs while `xfer_ready` is withdrawn every third cycle. The bench judges the end pulse type, the number of transfers and the width of each transfer against its own model of the address walk.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_XFER = 2'd2,
    SEQ_END  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/dma_width_pick.sv
module dma_width_pick #(
  parameter int CNT_W = 5
) (
  input  logic             addr_lsb,
  input  logic [CNT_W-1:0] rem,
  input  logic             byte_only,
  output logic             wide
);
  localparam logic [CNT_W-1:0] PAIR = CNT_W'(2);

  always_comb begin
    wide = !byte_only && !addr_lsb && (rem >= PAIR);
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 32,
  parameter int LO_W   = 8,
  parameter int CNT_W  = 5
) (
  input  logic [ADDR_W-1:0]      cur_addr,
  input  logic [CNT_W-1:0]       rem,
  input  logic                   wide,
  input  logic [ADDR_W-LO_W-1:0] page_lat,
  output logic [ADDR_W-1:0]      nxt_addr,
  output logic [CNT_W-1:0]       nxt_rem,
  output logic                   last,
  output logic                   page_cross
);
  always_comb begin
    nxt_addr   = cur_addr + (wide ? ADDR_W'(2) : ADDR_W'(1));
    nxt_rem    = rem - (wide ? CNT_W'(2) : CNT_W'(1));
    last       = (nxt_rem == '0);
    page_cross = (nxt_addr[ADDR_W-1:LO_W] != page_lat);
  end
endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LO_W      = 8,
  parameter int MAX_BYTES = 16,
  parameter int CNT_W     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      start_addr,
  input  logic [CNT_W-1:0]       byte_count,
  input  logic                   force_byte,
  input  logic                   xfer_ready,
  input  logic                   wide,
  input  logic [ADDR_W-1:0]      nxt_addr,
  input  logic [CNT_W-1:0]       nxt_rem,
  input  logic                   last,
  input  logic                   page_cross,
  output logic [ADDR_W-1:0]      cur_addr,
  output logic [CNT_W-1:0]       rem,
  output logic                   byte_only,
  output logic [ADDR_W-LO_W-1:0] page_lat,
  output logic                   busy,
  output logic                   ld_stb,
  output logic                   xfer_valid,
  output logic                   done,
  output logic                   yield
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_BYTES);

  seq_state_t       state;
  logic             stop_yield;
  logic [CNT_W-1:0] cnt_cap;
  logic             fire;

  always_comb begin
    cnt_cap = (byte_count > CAP) ? CAP : byte_count;
    fire    = (state == SEQ_XFER) && xfer_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      cur_addr   <= '0;
      rem        <= '0;
      byte_only  <= 1'b0;
      page_lat   <= '0;
      stop_yield <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: if (start) begin
          cur_addr   <= start_addr;
          rem        <= cnt_cap;
          byte_only  <= force_byte;
          page_lat   <= start_addr[ADDR_W-1:LO_W];
          stop_yield <= 1'b0;
          state      <= (cnt_cap == '0) ? SEQ_END : SEQ_LOAD;
        end
        SEQ_LOAD: state <= SEQ_XFER;
        SEQ_XFER: if (fire) begin
          cur_addr <= nxt_addr;
          rem      <= nxt_rem;
          if (last) begin
            state <= SEQ_END;
          end else if (page_cross) begin
            state      <= SEQ_END;
            stop_yield <= 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = (state != SEQ_IDLE);
    ld_stb     = (state == SEQ_LOAD);
    xfer_valid = (state == SEQ_XFER);
    done       = (state == SEQ_END) && !stop_yield;
    yield      = (state == SEQ_END) && stop_yield;
  end

  AST_WIDE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && wide |-> !cur_addr[0] && (rem >= CNT_W'(2))); // R3
  AST_FORCE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && byte_only |-> !wide); // R5
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> !ld_stb && xfer_valid); // R2
  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(cur_addr) && $stable(wide)); // R7
  AST_YIELD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(yield) |-> $past(page_cross && !last && xfer_ready)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R8
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq #(
  parameter int ADDR_W    = 32,
  parameter int LO_W      = 8,
  parameter int MAX_BYTES = 16,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      start_addr,
  input  logic [CNT_W-1:0]       byte_count,
  input  logic                   force_byte,
  output logic                   busy,
  output logic                   ld_stb,
  output logic [ADDR_W-LO_W-1:0] upper_addr,
  output logic                   xfer_valid,
  input  logic                   xfer_ready,
  output logic [LO_W-1:0]        xfer_lo_addr,
  output logic                   xfer_wide,
  output logic                   done,
  output logic                   yield
);
  localparam int HI_W = ADDR_W - LO_W;

  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [CNT_W-1:0]  rem, nxt_rem;
  logic              byte_only, wide, last, page_cross;
  logic [HI_W-1:0]   page_lat;

  dma_width_pick #(.CNT_W(CNT_W)) u_pick (
    .addr_lsb (cur_addr[0]),
    .rem      (rem),
    .byte_only(byte_only),
    .wide     (wide)
  );

  dma_addr_step #(.ADDR_W(ADDR_W), .LO_W(LO_W), .CNT_W(CNT_W)) u_step (
    .cur_addr  (cur_addr),
    .rem       (rem),
    .wide      (wide),
    .page_lat  (page_lat),
    .nxt_addr  (nxt_addr),
    .nxt_rem   (nxt_rem),
    .last      (last),
    .page_cross(page_cross)
  );

  dma_burst_ctrl #(.ADDR_W(ADDR_W), .LO_W(LO_W), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_addr(start_addr),
    .byte_count(byte_count),
    .force_byte(force_byte),
    .xfer_ready(xfer_ready),
    .wide      (wide),
    .nxt_addr  (nxt_addr),
    .nxt_rem   (nxt_rem),
    .last      (last),
    .page_cross(page_cross),
    .cur_addr  (cur_addr),
    .rem       (rem),
    .byte_only (byte_only),
    .page_lat  (page_lat),
    .busy      (busy),
    .ld_stb    (ld_stb),
    .xfer_valid(xfer_valid),
    .done      (done),
    .yield     (yield)
  );

  always_comb begin
    upper_addr   = page_lat;
    xfer_lo_addr = cur_addr[LO_W-1:0];
    xfer_wide    = wide;
  end
endmodule

// File: tb/dma_burst_seq_test.sv
`timescale 1ns/1ps
module dma_burst_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [4:0]  byte_count = '0;
  logic        force_byte = 1'b0;
  logic        xfer_ready = 1'b0;
  logic        busy, ld_stb, xfer_valid, xfer_wide, done, yield;
  logic [23:0] upper_addr;
  logic [7:0]  xfer_lo_addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .force_byte(force_byte), .busy(busy),
    .ld_stb(ld_stb), .upper_addr(upper_addr), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_lo_addr(xfer_lo_addr), .xfer_wide(xfer_wide),
    .done(done), .yield(yield)
  );

  localparam int NV = 12;
  localparam logic [31:0] V_ADDR [NV] = '{32'h1000_0010, 32'h1000_0010, 32'h1000_0011,
    32'h1000_0011, 32'h1000_0010, 32'h2000_00FC, 32'h2000_00FF, 32'h3000_0000,
    32'h3000_0001, 32'h3000_0000, 32'h4000_00FE, 32'h1234_5601};
  localparam logic [4:0] V_CNT [NV] = '{5'd8, 5'd7, 5'd7, 5'd6, 5'd5, 5'd10, 5'd4,
    5'd16, 5'd16, 5'd25, 5'd2, 5'd1};
  localparam logic V_FRC [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0};
  localparam int V_NX [NV] = '{4, 4, 4, 4, 5, 2, 1, 8, 9, 8, 1, 1};
  localparam int V_NW [NV] = '{4, 3, 3, 2, 0, 2, 0, 8, 7, 8, 1, 0};
  localparam logic V_YLD [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0};

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_burst(input logic [31:0] a, input logic [4:0] c, input logic f,
                           input int en, input int ew, input logic ey,
                           input bit poke, input string rq);
    logic [31:0] ma = a;
    int mrem = (c > 5'd16) ? 16 : int'(c);
    int nx = 0, nw = 0, extra = 0;
    bit stalled = 0, ended = 0;
    logic [7:0] p_lo = '0;
    logic p_w = 0;
    @(negedge clk);
    start = 1'b1; start_addr = a; byte_count = c; force_byte = f; xfer_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(ld_stb == 1'b1 && xfer_valid == 1'b0, "R2", "ld_stb after start", ld_stb, 1);
    chk(upper_addr == a[31:8], "R2", "upper_addr", upper_addr, a[31:8]);
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && t == 3) begin
        start = 1'b1; start_addr = 32'hDEAD_0001; byte_count = 5'd9; force_byte = 1'b1;
      end
      if (ld_stb) extra++;
      if (done || yield) begin
        ended = 1;
        chk(yield == ey && done == !ey, ey ? "R9" : "R8", "end pulse yield", yield, ey);
        chk(nx == en, rq, "transfer count", nx, en);
        chk(nw == ew, rq, "wide count", nw, ew);
        chk(extra == 0, "R2", "extra ld_stb", extra, 0);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && yield == 1'b0, "R8", "idle after end", busy, 0);
        break;
      end
      if (xfer_valid) begin
        bit ew_now = !f && !ma[0] && (mrem >= 2);
        string wr = f ? "R5" : ((!ma[0] && mrem >= 2) ? "R3" : "R4");
        if (stalled)
          chk(xfer_lo_addr == p_lo && xfer_wide == p_w, "R7", "offer held", xfer_lo_addr, p_lo);
        chk(xfer_lo_addr == ma[7:0], "R6", "low address", xfer_lo_addr, ma[7:0]);
        chk(xfer_wide == ew_now, wr, "width", xfer_wide, ew_now);
        p_lo = xfer_lo_addr; p_w = xfer_wide;
        xfer_ready = ((t % 3) != 1);
        stalled = !xfer_ready;
        if (xfer_ready) begin
          nx++;
          if (ew_now) begin nw++; ma += 2; mrem -= 2; end
          else begin ma += 1; mrem -= 1; end
        end
      end else begin
        xfer_ready = 1'b0;
      end
    end
    start = 1'b0;
    xfer_ready = 1'b0;
    if (!ended) chk(1'b0, rq, "burst never ended", 0, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual=%0d expected<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !xfer_valid && !ld_stb && !done && !yield, "R1", "reset idle",
        {busy, xfer_valid, ld_stb, done, yield}, 0);

    for (int i = 0; i < NV; i++)
      run_burst(V_ADDR[i], V_CNT[i], V_FRC[i], V_NX[i], V_NW[i], V_YLD[i], 1'b0,
                (i == 9) ? "R11" : "R8");

    // R1: start pulsed mid-burst must not disturb the walk
    run_burst(32'h5000_0020, 5'd12, 1'b0, 6, 6, 1'b0, 1'b1, "R1");

    // R10: zero count
    @(negedge clk);
    start = 1'b1; start_addr = 32'h6000_0040; byte_count = 5'd0; force_byte = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1 && ld_stb == 1'b0 && xfer_valid == 1'b0, "R10", "zero count done",
        {done, ld_stb, xfer_valid}, 3'b100);
    @(negedge clk);
    chk(!busy && !xfer_valid && !ld_stb, "R10", "zero count idle",
        {busy, xfer_valid, ld_stb}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule